// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Unit

This unit tracks, for one processor, which interrupt is being serviced and which ones it preempted. A distributor outside this block picks the highest-priority pending interrupt and offers its number on `pend_id`. When the processor takes an interrupt (`ack_req`), the unit decides whether the offer may preempt the work in progress. If it may, the unit returns its number, makes it the running interrupt, remembers the interrupt it displaced and emits a strobe that clears its pending state. If it may not, the unit returns the spurious number 1023.

When the processor signals completion (`eoi_req`), the number sits in the low ten bits of the written word. Completing the running interrupt restores its predecessor and the predecessor's priority. Completing an interrupt that is deeper in the preemption chain removes it from the middle of the chain. A small walker does this by following one link per clock, and it raises `busy` while it works. Completion of a level-sensitive source whose line is still high, that is enabled and that is routed to this processor produces a strobe that makes it pending again.

Priorities and the per-interrupt configuration bits come in as flat vectors from the distributor. The predecessor links are kept inside, one per implemented interrupt, and reset to 1023. The unit assumes `NUM_IRQ` is a power of two of at most 1020. It also assumes that the processor does not raise an acknowledge and a completion in the same cycle; if it does, the acknowledge is served and the completion is dropped.

Top module: `ackeoi_unit`

## Requirements
- R1: An acknowledge is refused when `pend_id` is 1023, is not below `NUM_IRQ`, or has a priority (8 bits, lower value is more urgent) not strictly below `run_prio`. A refused acknowledge answers 1023, leaves `run_id` and `run_prio` unchanged and emits no clear strobe.
- R2: An accepted acknowledge answers `pend_id` on `ack_id` with `ack_valid` one cycle after the request. In that same cycle `run_id` becomes the new number and `run_prio` its priority, and the old running number is stored as its predecessor.
- R3: Each accepted acknowledge emits `pclr_valid` with `pclr_id` equal to the answered number in the answer cycle. `pclr_mask` has only bit `CPU_ID` set when the interrupt's `model_all` bit is 0, and all `NUM_CPU` bits set when that bit is 1.
- R4: After reset `run_id` is 1023, `run_prio` is 9'h100, `busy` is 0 and no strobe is active. `run_prio` is 9'h100 whenever `run_id` is 1023.
- R5: The completion number is `eoi_data[9:0]`. A completion is ignored when that number is not below `NUM_IRQ` or when `run_id` is 1023: no state change, no `busy`, no set strobe.
- R6: A completion that is not ignored emits `pset_valid` with `pset_id` equal to the completed number one cycle later when its `trig_edge` bit is 0 (level), its `irq_en` bit is 1, its `line_lvl` bit is 1 and its `tgt_here` bit is 1. Otherwise no set strobe follows.
- R7: Completing the running interrupt moves `run_id` to its stored predecessor one cycle later. `run_prio` becomes that predecessor's priority, or 9'h100 when the predecessor is 1023. `busy` stays low.
- R8: Completing a number that is not the running one holds `busy` high from the next cycle for one cycle per link examined, starting at the running interrupt. The walk lasts d cycles when the number is the d-th predecessor, in which case it is unlinked, and L cycles when it is absent from a chain of L entries, in which case nothing changes. `run_id` holds throughout.
- R9: While `busy` is high, acknowledge and completion requests are dropped: no answer, no strobe, no change to the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_req | input | 1 | Processor takes an interrupt this cycle |
| pend_id | input | 10 | Highest pending number offered by the distributor, 1023 for none |
| eoi_req | input | 1 | Processor signals completion this cycle |
| eoi_data | input | 32 | Completion word; bits 9:0 carry the number |
| prio_flat | input | NUM_IRQ*8 | Priority of interrupt i in bits [8i+7:8i] |
| trig_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| model_all | input | NUM_IRQ | 1 = acknowledge clears pending on all processors |
| irq_en | input | NUM_IRQ | Enable bit of each interrupt for this processor |
| line_lvl | input | NUM_IRQ | Current level of each source line |
| tgt_here | input | NUM_IRQ | Interrupt is routed to this processor |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_id | output | 10 | Answered number, 1023 when refused |
| run_id | output | 10 | Running interrupt, 1023 when idle |
| run_prio | output | 9 | Running priority, 9'h100 when idle |
| pclr_valid | output | 1 | Clear-pending strobe |
| pclr_id | output | 10 | Number to clear |
| pclr_mask | output | NUM_CPU | Processors whose pending bit is cleared |
| pset_valid | output | 1 | Set-pending strobe for this processor |
| pset_id | output | 10 | Number to make pending again |
| busy | output | 1 | Chain walk in progress; requests are dropped |

## Verification
The acknowledge answer, the clear strobe and the new running number and priority all appear one cycle after the request cycle. The set strobe and a completion pop also appear one cycle after the completion cycle. `busy` rises in that same next cycle and stays high for exactly one cycle per examined link. The bench drives every request on a falling edge and holds it for one cycle. It samples at the falling edge after the capturing rising edge, where a scoreboard pops the expected answers and strobes; any strobe that arrives with no expectation queued is a failure. Walk length is measured by counting falling edges with `busy` high and comparing against the chain depth computed from the acknowledge sequence.

// File: rtl/ackeoi_pkg.sv
// Shared constants and types for the acknowledge/completion nesting unit.
// Assumes ten-bit interrupt numbers and eight-bit priorities.
package ackeoi_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W:0]   run_prio_t;

    localparam irq_id_t   SPURIOUS_ID = 10'd1023;
    localparam run_prio_t IDLE_PRIO   = 9'h100;

    typedef enum logic {
        WALK_IDLE,
        WALK_STEP
    } walk_state_e;
endpackage

// File: rtl/ackeoi_admit.sv
// Decides whether an offered interrupt may preempt the running one and
// which processors lose its pending state. Purely combinational.
// Assumes the caller gates the result with the request and busy flags.
module ackeoi_admit
    import ackeoi_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_ID  = 0
) (
    input  irq_id_t             pend_id,
    input  logic [PRIO_W-1:0]   pend_prio,
    input  logic                pend_model,
    input  run_prio_t           run_prio,
    output logic                take,
    output logic [NUM_CPU-1:0]  clr_mask
);
    localparam logic [NUM_CPU-1:0] OWN_MASK = NUM_CPU'(1) << CPU_ID;
    localparam logic [NUM_CPU-1:0] ALL_MASK = {NUM_CPU{1'b1}};

    // Accept only a real, implemented number strictly more urgent than the running one.
    always_comb begin
        take = (pend_id != SPURIOUS_ID)
            && (pend_id < ID_W'(NUM_IRQ))
            && ({1'b0, pend_prio} < run_prio);
    end

    // Pick own processor or every processor for the clear strobe.
    always_comb begin
        clr_mask = pend_model ? ALL_MASK : OWN_MASK;
    end
endmodule

// File: rtl/ackeoi_repend.sv
// Tells whether a completed interrupt must become pending again: it has
// to be level-sensitive, enabled, still high and routed here.
// Assumes the number has already been checked against NUM_IRQ.
module ackeoi_repend
    import ackeoi_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  irq_id_t              done_id,
    input  logic [NUM_IRQ-1:0]   trig_edge,
    input  logic [NUM_IRQ-1:0]   irq_en,
    input  logic [NUM_IRQ-1:0]   line_lvl,
    input  logic [NUM_IRQ-1:0]   tgt_here,
    output logic                 hit
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [IDX_W-1:0] idx;
    logic             in_range;

    // Reduce the number to a table index and remember if it is implemented.
    always_comb begin
        idx      = done_id[IDX_W-1:0];
        in_range = done_id < ID_W'(NUM_IRQ);
    end

    // Combine the four qualifying bits.
    always_comb begin
        hit = in_range && !trig_edge[idx] && irq_en[idx]
            && line_lvl[idx] && tgt_here[idx];
    end
endmodule

// File: rtl/ackeoi_link_table.sv
// Predecessor link per interrupt number, with one write port and
// NUM_RD combinational read ports. Reads of numbers outside the table
// return the spurious number. All links reset to the spurious number.
module ackeoi_link_table
    import ackeoi_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_RD  = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  irq_id_t  wr_addr,
    input  irq_id_t  wr_data,
    input  irq_id_t  rd_addr [NUM_RD],
    output irq_id_t  rd_data [NUM_RD]
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    irq_id_t links [NUM_IRQ];

    // Store a link on request; clear the whole table on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                links[i] <= SPURIOUS_ID;
            end
        end else if (wr_en && (wr_addr < ID_W'(NUM_IRQ))) begin
            links[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    // One guarded read port per requested address.
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        always_comb begin
            if (rd_addr[r] < ID_W'(NUM_IRQ)) begin
                rd_data[r] = links[rd_addr[r][IDX_W-1:0]];
            end else begin
                rd_data[r] = SPURIOUS_ID;
            end
        end
    end
endmodule

// File: rtl/ackeoi_chain_walk.sv
// Walks the preemption chain one link per clock looking for a target
// number; on a hit it asks for the referring link to skip the target.
// Assumes the link table answers reads of cursor and target in-cycle.
module ackeoi_chain_walk
    import ackeoi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  irq_id_t  start_cursor,
    input  irq_id_t  start_target,
    input  irq_id_t  link_at_cursor,
    input  irq_id_t  link_at_target,
    output irq_id_t  cursor,
    output irq_id_t  target,
    output logic     wr_en,
    output irq_id_t  wr_addr,
    output irq_id_t  wr_data,
    output logic     busy
);
    walk_state_e state;
    logic        at_end;
    logic        found;

    // Classify the link examined in this step.
    always_comb begin
        at_end = (link_at_cursor == SPURIOUS_ID);
        found  = !at_end && (link_at_cursor == target);
    end

    // Advance the walk or finish it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WALK_IDLE;
            cursor <= SPURIOUS_ID;
            target <= SPURIOUS_ID;
        end else begin
            case (state)
                WALK_IDLE: begin
                    if (start) begin
                        cursor <= start_cursor;
                        target <= start_target;
                        state  <= WALK_STEP;
                    end
                end
                WALK_STEP: begin
                    if (at_end || found) begin
                        state <= WALK_IDLE;
                    end else begin
                        cursor <= link_at_cursor;
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    // Bypass request: referring link takes the target's predecessor.
    always_comb begin
        busy    = (state == WALK_STEP);
        wr_en   = busy && found;
        wr_addr = cursor;
        wr_data = link_at_target;
    end
endmodule

// File: rtl/ackeoi_unit.sv
// Per-processor acknowledge and completion nesting unit. Accepts an
// offered interrupt if it preempts the running one, keeps a chain of
// preempted numbers, retires completions from the top or the middle of
// that chain and re-pends level sources that are still asserted.
// Assumes NUM_IRQ is a power of two not above 1020 and that priority
// and configuration vectors are stable in the request cycle.
module ackeoi_unit
    import ackeoi_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_ID  = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ack_req,
    input  logic [9:0]                  pend_id,
    input  logic                        eoi_req,
    input  logic [31:0]                 eoi_data,
    input  logic [NUM_IRQ*8-1:0]        prio_flat,
    input  logic [NUM_IRQ-1:0]          trig_edge,
    input  logic [NUM_IRQ-1:0]          model_all,
    input  logic [NUM_IRQ-1:0]          irq_en,
    input  logic [NUM_IRQ-1:0]          line_lvl,
    input  logic [NUM_IRQ-1:0]          tgt_here,
    output logic                        ack_valid,
    output logic [9:0]                  ack_id,
    output logic [9:0]                  run_id,
    output logic [8:0]                  run_prio,
    output logic                        pclr_valid,
    output logic [9:0]                  pclr_id,
    output logic [NUM_CPU-1:0]          pclr_mask,
    output logic                        pset_valid,
    output logic [9:0]                  pset_id,
    output logic                        busy
);
    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int NUM_RD = 3;

    // Priority of an implemented number, zero otherwise.
    function automatic logic [PRIO_W-1:0] prio_of(input irq_id_t id);
        if (id < ID_W'(NUM_IRQ)) begin
            return prio_flat[int'(id[IDX_W-1:0])*PRIO_W +: PRIO_W];
        end
        return '0;
    endfunction

    irq_id_t             eoi_id;
    logic                unused_eoi_hi;
    logic                ack_fire;
    logic                take_raw;
    logic                take;
    logic [NUM_CPU-1:0]  clr_mask;
    logic                model_bit;
    logic                eoi_ok;
    logic                pop;
    logic                walk_start;
    logic                repend_hit;
    irq_id_t             pred_id;
    irq_id_t             walk_cursor;
    irq_id_t             walk_target;
    logic                walk_wr_en;
    irq_id_t             walk_wr_addr;
    irq_id_t             walk_wr_data;
    logic                tbl_wr_en;
    irq_id_t             tbl_wr_addr;
    irq_id_t             tbl_wr_data;
    irq_id_t             rd_addr [NUM_RD];
    irq_id_t             rd_data [NUM_RD];

    // Split the completion word and qualify both request kinds.
    always_comb begin
        eoi_id        = eoi_data[ID_W-1:0];
        unused_eoi_hi = ^eoi_data[31:ID_W];
        model_bit     = (pend_id < ID_W'(NUM_IRQ)) ? model_all[pend_id[IDX_W-1:0]] : 1'b0;
        ack_fire      = ack_req && !busy;
        take          = ack_fire && take_raw;
        eoi_ok        = eoi_req && !busy && !ack_req
                     && (eoi_id < ID_W'(NUM_IRQ)) && (run_id != SPURIOUS_ID);
        pop           = eoi_ok && (eoi_id == run_id);
        walk_start    = eoi_ok && (eoi_id != run_id);
    end

    ackeoi_admit #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_CPU (NUM_CPU),
        .CPU_ID  (CPU_ID)
    ) i_admit (
        .pend_id    (pend_id),
        .pend_prio  (prio_of(pend_id)),
        .pend_model (model_bit),
        .run_prio   (run_prio),
        .take       (take_raw),
        .clr_mask   (clr_mask)
    );

    ackeoi_repend #(
        .NUM_IRQ (NUM_IRQ)
    ) i_repend (
        .done_id   (eoi_id),
        .trig_edge (trig_edge),
        .irq_en    (irq_en),
        .line_lvl  (line_lvl),
        .tgt_here  (tgt_here),
        .hit       (repend_hit)
    );

    // Link table reads: predecessor of running, walk cursor, walk target.
    always_comb begin
        rd_addr[0] = run_id;
        rd_addr[1] = walk_cursor;
        rd_addr[2] = walk_target;
        pred_id    = rd_data[0];
    end

    // Write port: an accepted acknowledge records the preempted number,
    // otherwise the walker may bypass a link.
    always_comb begin
        if (take) begin
            tbl_wr_en   = 1'b1;
            tbl_wr_addr = pend_id;
            tbl_wr_data = run_id;
        end else begin
            tbl_wr_en   = walk_wr_en;
            tbl_wr_addr = walk_wr_addr;
            tbl_wr_data = walk_wr_data;
        end
    end

    ackeoi_link_table #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_RD  (NUM_RD)
    ) i_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ackeoi_chain_walk i_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (walk_start),
        .start_cursor   (run_id),
        .start_target   (eoi_id),
        .link_at_cursor (rd_data[1]),
        .link_at_target (rd_data[2]),
        .cursor         (walk_cursor),
        .target         (walk_target),
        .wr_en          (walk_wr_en),
        .wr_addr        (walk_wr_addr),
        .wr_data        (walk_wr_data),
        .busy           (busy)
    );

    // Answer, strobes and running state, all one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_id     <= SPURIOUS_ID;
            run_id     <= SPURIOUS_ID;
            run_prio   <= IDLE_PRIO;
            pclr_valid <= 1'b0;
            pclr_id    <= SPURIOUS_ID;
            pclr_mask  <= '0;
            pset_valid <= 1'b0;
            pset_id    <= SPURIOUS_ID;
        end else begin
            ack_valid  <= ack_fire;
            ack_id     <= take ? pend_id : SPURIOUS_ID;
            pclr_valid <= take;
            pclr_id    <= pend_id;
            pclr_mask  <= clr_mask;
            pset_valid <= eoi_ok && repend_hit;
            pset_id    <= eoi_id;
            if (take) begin
                run_id   <= pend_id;
                run_prio <= {1'b0, prio_of(pend_id)};
            end else if (pop) begin
                run_id   <= pred_id;
                run_prio <= (pred_id == SPURIOUS_ID) ? IDLE_PRIO : {1'b0, prio_of(pred_id)};
            end
        end
    end
endmodule

// File: rtl/ackeoi_unit_chk.sv
// Property checker for the nesting unit, attached by bind. Observes
// ports only and relates them across cycles.
module ackeoi_unit_chk
    import ackeoi_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ack_req,
    input logic        eoi_req,
    input logic [31:0] eoi_data,
    input logic        ack_valid,
    input logic [9:0]  ack_id,
    input logic [9:0]  run_id,
    input logic [8:0]  run_prio,
    input logic        pclr_valid,
    input logic [9:0]  pclr_id,
    input logic        pset_valid,
    input logic        busy
);
    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == SPURIOUS_ID) |-> (run_prio == IDLE_PRIO)); // R4

    AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == SPURIOUS_ID) |-> $stable(run_id)); // R1

    AST_ACK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != SPURIOUS_ID) |-> (run_id == ack_id)); // R2

    AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != SPURIOUS_ID) |-> (run_prio < $past(run_prio))); // R2

    AST_CLR_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        pclr_valid |-> (ack_valid && ack_id == pclr_id)); // R3

    AST_OOR_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !busy && !ack_req && eoi_data[9:0] >= 10'(NUM_IRQ))
        |=> ($stable(run_id) && !busy && !pset_valid)); // R5

    AST_PSET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        pset_valid |-> $past(eoi_req)); // R6

    AST_WALK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(run_id)); // R8

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_req) |=> !ack_valid); // R9
endmodule

bind ackeoi_unit ackeoi_unit_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req    (ack_req),
    .eoi_req    (eoi_req),
    .eoi_data   (eoi_data),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id),
    .run_id     (run_id),
    .run_prio   (run_prio),
    .pclr_valid (pclr_valid),
    .pclr_id    (pclr_id),
    .pset_valid (pset_valid),
    .busy       (busy)
);

// File: tb/test_ackeoi_unit.sv
// Scoreboard bench: driver tasks queue expected answers and strobes,
// a falling-edge monitor pops and compares them.
module test_ackeoi_unit;
    localparam int NIRQ = 64;
    localparam int NCPU = 2;
    localparam logic [9:0] SPUR = 10'd1023;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ack_req = 1'b0;
    logic [9:0]        pend_id = SPUR;
    logic              eoi_req = 1'b0;
    logic [31:0]       eoi_data = '0;
    logic [NIRQ*8-1:0] prio_flat;
    logic [NIRQ-1:0]   trig_edge = '0;
    logic [NIRQ-1:0]   model_all = '0;
    logic [NIRQ-1:0]   irq_en = '0;
    logic [NIRQ-1:0]   line_lvl = '0;
    logic [NIRQ-1:0]   tgt_here = '0;
    logic              ack_valid;
    logic [9:0]        ack_id;
    logic [9:0]        run_id;
    logic [8:0]        run_prio;
    logic              pclr_valid;
    logic [9:0]        pclr_id;
    logic [NCPU-1:0]   pclr_mask;
    logic              pset_valid;
    logic [9:0]        pset_id;
    logic              busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0]  exp_ack_q [$];
    logic [11:0] exp_clr_q [$];
    logic [9:0]  exp_set_q [$];

    always #2 clk = ~clk;

    ackeoi_unit #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .CPU_ID(0)) i_ackeoi_unit (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_id(pend_id),
        .eoi_req(eoi_req), .eoi_data(eoi_data), .prio_flat(prio_flat),
        .trig_edge(trig_edge), .model_all(model_all), .irq_en(irq_en),
        .line_lvl(line_lvl), .tgt_here(tgt_here), .ack_valid(ack_valid),
        .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
        .pclr_valid(pclr_valid), .pclr_id(pclr_id), .pclr_mask(pclr_mask),
        .pset_valid(pset_valid), .pset_id(pset_id), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: compare every answer and strobe against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_valid) begin : m_ack
                if (exp_ack_q.size() == 0) begin
                    chk("R9 unexpected ack answer", int'(ack_id), -1);
                end else begin
                    chk("R2 ack answer id", int'(ack_id), int'(exp_ack_q.pop_front()));
                end
            end
            if (pclr_valid) begin : m_clr
                if (exp_clr_q.size() == 0) begin
                    chk("R3 unexpected clear strobe", int'(pclr_id), -1);
                end else begin
                    chk("R3 clear strobe mask/id", int'({pclr_mask, pclr_id}),
                        int'(exp_clr_q.pop_front()));
                end
            end
            if (pset_valid) begin : m_set
                if (exp_set_q.size() == 0) begin
                    chk("R6 unexpected set strobe", int'(pset_id), -1);
                end else begin
                    chk("R6 set strobe id", int'(pset_id), int'(exp_set_q.pop_front()));
                end
            end
        end
    end

    // Driver: one acknowledge, then check the running state.
    task automatic do_ack(input logic [9:0] pend, input logic [9:0] exp_id,
                          input logic [1:0] exp_mask, input logic [9:0] exp_run,
                          input logic [8:0] exp_prio, input string tag);
        @(negedge clk);
        ack_req = 1'b1;
        pend_id = pend;
        exp_ack_q.push_back(exp_id);
        if (exp_id != SPUR) exp_clr_q.push_back({exp_mask, exp_id});
        @(negedge clk);
        ack_req = 1'b0;
        pend_id = SPUR;
        chk({tag, " run_id"}, int'(run_id), int'(exp_run));
        chk({tag, " run_prio"}, int'(run_prio), int'(exp_prio));
    endtask

    // Driver: one completion, count busy cycles, check the running state.
    task automatic do_eoi(input logic [31:0] word, input bit exp_set,
                          input int exp_busy, input logic [9:0] exp_run,
                          input logic [8:0] exp_prio, input string tag);
        int n;
        @(negedge clk);
        eoi_req  = 1'b1;
        eoi_data = word;
        if (exp_set) exp_set_q.push_back(word[9:0]);
        @(negedge clk);
        eoi_req = 1'b0;
        n = 0;
        while (busy && n < 64) begin
            n++;
            @(negedge clk);
        end
        chk({tag, " busy cycles"}, n, exp_busy);
        chk({tag, " run_id"}, int'(run_id), int'(exp_run));
        chk({tag, " run_prio"}, int'(run_prio), int'(exp_prio));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NIRQ; i++) prio_flat[i*8 +: 8] = 8'hF0;
        prio_flat[40*8 +: 8] = 8'h80;
        prio_flat[36*8 +: 8] = 8'h80;
        prio_flat[35*8 +: 8] = 8'h90;
        prio_flat[41*8 +: 8] = 8'h40;
        prio_flat[42*8 +: 8] = 8'h20;
        model_all[41] = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        chk("R4 reset run_id", int'(run_id), int'(SPUR));
        chk("R4 reset run_prio", int'(run_prio), 'h100);
        chk("R4 reset busy", int'(busy), 0);
        chk("R4 reset strobes", int'({ack_valid, pclr_valid, pset_valid}), 0);

        // R1 refusals and R2/R3 acceptances
        do_ack(SPUR,  SPUR, 2'b00, SPUR, 9'h100, "R1 none pending");
        do_ack(10'd70, SPUR, 2'b00, SPUR, 9'h100, "R1 unimplemented number");
        do_ack(10'd40, 10'd40, 2'b01, 10'd40, 9'h080, "R2 first ack");
        do_ack(10'd35, SPUR, 2'b00, 10'd40, 9'h080, "R1 less urgent");
        do_ack(10'd36, SPUR, 2'b00, 10'd40, 9'h080, "R1 equal priority");
        do_ack(10'd41, 10'd41, 2'b11, 10'd41, 9'h040, "R3 all-cpu clear");
        do_ack(10'd42, 10'd42, 2'b01, 10'd42, 9'h020, "R2 nested ack");

        // R8 unlink from the middle: 42 -> 41 -> 40, 41 is depth 1
        do_eoi(32'd41, 1'b0, 1, 10'd42, 9'h020, "R8 unlink middle");
        // R5 out-of-range number
        do_eoi(32'd100, 1'b0, 0, 10'd42, 9'h020, "R5 out of range");
        // R7 pop now skips 41
        do_eoi(32'd42, 1'b0, 0, 10'd40, 9'h080, "R7 pop to predecessor");
        // R5 only low ten bits count
        do_eoi(32'hFFFF_FC28, 1'b0, 0, SPUR, 9'h100, "R5 low bits, R7 pop to idle");

        // R6 re-pend setup: level, enabled, high, routed
        irq_en[40] = 1'b1; line_lvl[40] = 1'b1; tgt_here[40] = 1'b1;
        do_eoi(32'd40, 1'b0, 0, SPUR, 9'h100, "R5 nothing running");
        do_ack(10'd40, 10'd40, 2'b01, 10'd40, 9'h080, "R2 ack again");
        do_eoi(32'd40, 1'b1, 0, SPUR, 9'h100, "R6 level still high");
        do_ack(10'd40, 10'd40, 2'b01, 10'd40, 9'h080, "R2 ack edge case");
        trig_edge[40] = 1'b1;
        do_eoi(32'd40, 1'b0, 0, SPUR, 9'h100, "R6 edge no re-pend");

        // R8 absent number, R9 request dropped while busy
        do_ack(10'd40, 10'd40, 2'b01, 10'd40, 9'h080, "R2 chain base");
        do_ack(10'd41, 10'd41, 2'b11, 10'd41, 9'h040, "R2 chain top");
        begin : walk_miss
            int n;
            @(negedge clk);
            eoi_req  = 1'b1;
            eoi_data = 32'd50;
            @(negedge clk);
            eoi_req = 1'b0;
            ack_req = 1'b1;
            pend_id = 10'd42;
            n = 0;
            if (busy) n++;
            @(negedge clk);
            ack_req = 1'b0;
            pend_id = SPUR;
            while (busy && n < 64) begin
                n++;
                @(negedge clk);
            end
            chk("R8 absent number walk length", n, 2);
            chk("R9 run_id after dropped ack", int'(run_id), 41);
            chk("R9 run_prio after dropped ack", int'(run_prio), 'h040);
        end
        do_eoi(32'd41, 1'b0, 0, 10'd40, 9'h080, "R7 pop after miss");
        do_eoi(32'd40, 1'b0, 0, SPUR, 9'h100, "R7 pop last");

        repeat (3) @(negedge clk);
        chk("R2 ack queue drained", exp_ack_q.size(), 0);
        chk("R3 clear queue drained", exp_clr_q.size(), 0);
        chk("R6 set queue drained", exp_set_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule